// File: doc/BRIEF.md
# Priority-Preemptive Thread Dispatch Engine

This block is a dispatcher placed beside the cores rather than inside any of them. It holds one run queue of thread handles per priority level and a small vector table that maps interrupt, exception and call sources to a level, a handle and a set of allowed cores. Commands reach it as word-framed messages on one serialized port. Because it also keeps a record of the level each core is running at, it alone decides when a core is preempted, and no lock is needed in software to do so.

When the head of a run queue outranks some core that the thread is allowed to use, the engine sends a one-cycle dispatch notice naming the core, the handle and the level. The thread state and register words are then moved by the memory side, which is not part of this block. If that core was already busy, the displaced thread is held per core until the core reports its state returned. The thread is then put back at the front of its level. On every return or exit, the engine reports the run time of the thread that left the core, measured against the real-time-clock input.

Top module: `thread_dispatch`

## Requirements
- R1: A message is one or more words framed by `in_last`. Only the first word (header) carries the command: op in bits 31:28, handle in 27:20, level in 19:14, core mask in 13:6, and vector or core index in 5:0. The command takes effect in the cycle of the last word, and any further words are ignored. Op codes are 1 set-vector, 2 enqueue, 3 interrupt, 4 state-returned, 5 exit.
- R2: An enqueue appends its handle and mask at the tail of the named level, so threads of one level leave in arrival order.
- R3: An interrupt message names a vector. The level, handle and mask last written to that vector by set-vector decide which queue the work joins.
- R4: A core whose recorded priority is p gets a thread of level L only if L+1 > p, where an idle core has p = 0. A thread at equal or lower rank stays queued.
- R5: Among the allowed cores that qualify, the engine picks the one at the lowest recorded priority, and ties go to the lowest core index. Higher levels are served first, and only the head of each queue is considered.
- R6: A dispatch to a busy core holds the displaced thread. A state-returned message for that core puts it at the head of its level, ahead of threads already queued. A state-returned message for a core with nothing held has no effect.
- R7: On state-returned or exit, the engine gives one accounting record in the next cycle. The record holds the handle and the `rtc` value at the message minus the `rtc` value when that thread was dispatched. Exit makes the core idle.
- R8: An enqueue into a full queue is rejected and sets that level's sticky overflow flag. Entries already queued are kept unchanged.
- R9: At most one dispatch is issued per cycle, one cycle after the decision. The core's recorded priority takes the new level at once, so a second candidate is judged on the updated value.
- R10: Reset empties all queues, makes every core idle and clears the dispatch, accounting and overflow outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Message word valid |
| in_data | input | 32 | Message word |
| in_last | input | 1 | Last word of the message |
| rtc | input | 32 | Real-time-clock value |
| dsp_valid | output | 1 | Dispatch notice valid |
| dsp_core | output | 2 | Target core |
| dsp_handle | output | 8 | Dispatched thread handle |
| dsp_level | output | 3 | Level of the dispatched thread |
| acct_valid | output | 1 | Accounting record valid |
| acct_handle | output | 8 | Thread charged |
| acct_time | output | 32 | Run time charged |
| q_ovf | output | 8 | Sticky overflow flag per level |

## Verification
The bench runs a scripted sequence of cores and threads and goes after these corner cases:
- Ties between equally loaded cores. A wrong tie-break sends the thread to core 1 or to an unmasked core.
- A candidate of equal rank. A non-strict compare would preempt here.
- A returned thread that must overtake a queued thread of its own level. A tail requeue leaves the next dispatch stalled behind a thread that cannot run.
- Trailing words shaped like enqueue headers. These would dispatch a thread if parsed.
- Five enqueues into a four-deep queue, which must still drain its first four threads in order.
- Two back-to-back candidates for one core, which must give a single dispatch.

// File: rtl/tde_pkg.sv
package tde_pkg;
  localparam int DATA_W = 32;
  localparam int F_OP   = 28;
  localparam int F_HND  = 20;
  localparam int F_LVL  = 14;
  localparam int F_MSK  = 6;
  localparam int F_IDX  = 0;

  typedef enum logic [3:0] {
    OP_SETVEC = 4'd1,
    OP_ENQ    = 4'd2,
    OP_IRQ    = 4'd3,
    OP_RET    = 4'd4,
    OP_EXIT   = 4'd5
  } op_e;
endpackage

// File: rtl/tde_msg_rx.sv
module tde_msg_rx #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          cmd_fire,
  output logic [DW-1:0] cmd_word
);
  logic          mid_q, mid_n;
  logic [DW-1:0] hdr_q, hdr_n;

  always_comb begin
    mid_n = mid_q;
    hdr_n = hdr_q;
    if (in_valid) begin
      if (!mid_q) hdr_n = in_data;
      mid_n = !in_last;
    end
  end

  assign cmd_fire = in_valid && in_last;
  assign cmd_word = mid_q ? hdr_q : in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= 1'b0;
      hdr_q <= '0;
    end else begin
      mid_q <= mid_n;
      hdr_q <= hdr_n;
    end
  end

  // R1: the header is frozen while continuation words stream in
  a_r1_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_q && in_valid) |=> (hdr_q == $past(hdr_q)));
endmodule

// File: rtl/tde_queue.sv
module tde_queue #(
  parameter int EW = 12,
  parameter int QD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_tail,
  input  logic          push_head,
  input  logic          pop,
  input  logic [EW-1:0] din,
  output logic [EW-1:0] head,
  output logic          empty,
  output logic          ovf
);
  localparam int AW   = (QD > 1) ? $clog2(QD) : 1;
  localparam int CNTW = AW + 1;

  logic [EW-1:0]   mem [QD];
  logic [AW-1:0]   hd_q, hd_n, wr_ptr;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic            ovf_q, ovf_n, wr_en, full;

  assign full  = (cnt_q == CNTW'(QD));
  assign empty = (cnt_q == '0);
  assign head  = mem[hd_q];
  assign ovf   = ovf_q;

  always_comb begin
    hd_n   = hd_q;
    cnt_n  = cnt_q;
    ovf_n  = ovf_q;
    wr_en  = 1'b0;
    wr_ptr = hd_q + cnt_q[AW-1:0];
    if (push_tail || push_head) begin
      if (full) begin
        ovf_n = 1'b1;
      end else begin
        wr_en = 1'b1;
        cnt_n = cnt_q + CNTW'(1);
        if (push_head) begin
          hd_n   = hd_q - AW'(1);
          wr_ptr = hd_q - AW'(1);
        end
      end
    end else if (pop && !empty) begin
      hd_n  = hd_q + AW'(1);
      cnt_n = cnt_q - CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      hd_q  <= hd_n;
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= din;
  end

  a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r2_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_tail, push_head, pop}));
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(QD));
  a_r8_full_reject: assert property (@(posedge clk) disable iff (!rst_n)
    ((push_tail || push_head) && full) |=> (cnt_q == $past(cnt_q) && ovf_q));
endmodule

// File: rtl/tde_select.sv
module tde_select #(
  parameter int NL = 8,
  parameter int NC = 4,
  parameter int PW = 4,
  parameter int LW = 3,
  parameter int CW = 2
) (
  input  logic          head_v [NL],
  input  logic [NC-1:0] head_m [NL],
  input  logic [PW-1:0] core_prio [NC],
  input  logic [NC-1:0] core_blk,
  output logic          fire,
  output logic [LW-1:0] lvl,
  output logic [CW-1:0] core
);
  logic          found;
  logic [PW-1:0] bestp;
  logic [CW-1:0] bc;

  always_comb begin
    fire  = 1'b0;
    lvl   = '0;
    core  = '0;
    found = 1'b0;
    bestp = '0;
    bc    = '0;
    for (int l = NL - 1; l >= 0; l--) begin
      if (!fire && head_v[l]) begin
        found = 1'b0;
        bestp = '0;
        bc    = '0;
        for (int c = 0; c < NC; c++) begin
          if (head_m[l][c] && !core_blk[c] && (PW'(l + 1) > core_prio[c]) &&
              (!found || core_prio[c] < bestp)) begin
            found = 1'b1;
            bestp = core_prio[c];
            bc    = CW'(c);
          end
        end
        if (found) begin
          fire = 1'b1;
          lvl  = LW'(l);
          core = bc;
        end
      end
    end
  end
endmodule

// File: rtl/thread_dispatch.sv
module thread_dispatch
  import tde_pkg::*;
#(
  parameter int NUM_LEVELS  = 8,
  parameter int NUM_CORES   = 4,
  parameter int QUEUE_DEPTH = 4,
  parameter int NUM_VECTORS = 8,
  parameter int HANDLE_W    = 8,
  parameter int TIME_W      = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [DATA_W-1:0]             in_data,
  input  logic                          in_last,
  input  logic [TIME_W-1:0]             rtc,
  output logic                          dsp_valid,
  output logic [$clog2(NUM_CORES)-1:0]  dsp_core,
  output logic [HANDLE_W-1:0]           dsp_handle,
  output logic [$clog2(NUM_LEVELS)-1:0] dsp_level,
  output logic                          acct_valid,
  output logic [HANDLE_W-1:0]           acct_handle,
  output logic [TIME_W-1:0]             acct_time,
  output logic [NUM_LEVELS-1:0]         q_ovf
);
  localparam int NL = NUM_LEVELS;
  localparam int NC = NUM_CORES;
  localparam int LW = $clog2(NUM_LEVELS);
  localparam int CW = $clog2(NUM_CORES);
  localparam int VW = $clog2(NUM_VECTORS);
  localparam int PW = $clog2(NUM_LEVELS + 1);
  localparam int EW = HANDLE_W + NUM_CORES;

  logic              cmd_fire;
  logic [DATA_W-1:0] cmd_word;
  logic              unused_hdr;

  tde_msg_rx #(.DW(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .cmd_fire(cmd_fire), .cmd_word(cmd_word)
  );
  assign unused_hdr = ^cmd_word;

  logic [3:0]          c_op;
  logic [HANDLE_W-1:0] c_hnd;
  logic [LW-1:0]       c_lvl;
  logic [NC-1:0]       c_msk;
  logic [VW-1:0]       c_vec;
  logic [CW-1:0]       c_core;
  assign c_op   = cmd_word[F_OP +: 4];
  assign c_hnd  = cmd_word[F_HND +: HANDLE_W];
  assign c_lvl  = cmd_word[F_LVL +: LW];
  assign c_msk  = cmd_word[F_MSK +: NC];
  assign c_vec  = cmd_word[F_IDX +: VW];
  assign c_core = cmd_word[F_IDX +: CW];

  logic is_set, is_enq, is_irq, is_ret, is_exit, ret_ok, go;
  assign is_set  = cmd_fire && (c_op == OP_SETVEC);
  assign is_enq  = cmd_fire && (c_op == OP_ENQ);
  assign is_irq  = cmd_fire && (c_op == OP_IRQ);
  assign is_ret  = cmd_fire && (c_op == OP_RET);
  assign is_exit = cmd_fire && (c_op == OP_EXIT);

  // vector table
  logic [LW-1:0]       vt_lvl [NUM_VECTORS];
  logic [HANDLE_W-1:0] vt_h   [NUM_VECTORS];
  logic [NC-1:0]       vt_m   [NUM_VECTORS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NUM_VECTORS; v++) begin
        vt_lvl[v] <= '0;
        vt_h[v]   <= '0;
        vt_m[v]   <= '0;
      end
    end else if (is_set) begin
      vt_lvl[c_vec] <= c_lvl;
      vt_h[c_vec]   <= c_hnd;
      vt_m[c_vec]   <= c_msk;
    end
  end

  // per-core state
  logic [PW-1:0]       prio_q [NC], prio_n [NC];
  logic [HANDLE_W-1:0] run_h_q [NC], run_h_n [NC];
  logic [NC-1:0]       run_m_q [NC], run_m_n [NC];
  logic [TIME_W-1:0]   run_t_q [NC], run_t_n [NC];
  logic [NC-1:0]       pend_v_q, pend_v_n;
  logic [HANDLE_W-1:0] pend_h_q [NC], pend_h_n [NC];
  logic [NC-1:0]       pend_m_q [NC], pend_m_n [NC];
  logic [LW-1:0]       pend_l_q [NC], pend_l_n [NC];
  logic [TIME_W-1:0]   pend_t_q [NC], pend_t_n [NC];

  assign ret_ok = is_ret && pend_v_q[c_core];

  // queues
  logic [LW-1:0]       tail_lvl;
  logic [EW-1:0]       q_din;
  logic [EW-1:0]       q_head [NL];
  logic                head_v [NL];
  logic [NC-1:0]       head_m [NL];
  logic [HANDLE_W-1:0] head_h [NL];
  logic                sel_fire;
  logic [LW-1:0]       sel_lvl;
  logic [CW-1:0]       sel_core;

  assign tail_lvl = is_irq ? vt_lvl[c_vec] : c_lvl;
  assign q_din = ret_ok ? {pend_h_q[c_core], pend_m_q[c_core]} :
                 is_irq ? {vt_h[c_vec], vt_m[c_vec]} : {c_hnd, c_msk};
  assign go = sel_fire && !cmd_fire;

  for (genvar l = 0; l < NL; l++) begin : g_lvl
    logic q_empty;
    tde_queue #(.EW(EW), .QD(QUEUE_DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n),
      .push_tail((is_enq || is_irq) && tail_lvl == LW'(l)),
      .push_head(ret_ok && pend_l_q[c_core] == LW'(l)),
      .pop(go && sel_lvl == LW'(l)),
      .din(q_din), .head(q_head[l]), .empty(q_empty), .ovf(q_ovf[l])
    );
    assign head_v[l] = !q_empty;
    assign head_h[l] = q_head[l][EW-1:NC];
    assign head_m[l] = q_head[l][NC-1:0];
  end

  tde_select #(.NL(NL), .NC(NC), .PW(PW), .LW(LW), .CW(CW)) u_sel (
    .head_v(head_v), .head_m(head_m), .core_prio(prio_q), .core_blk(pend_v_q),
    .fire(sel_fire), .lvl(sel_lvl), .core(sel_core)
  );

  // outputs
  logic                dsp_v_n, acct_v_n;
  logic [CW-1:0]       dsp_c_n;
  logic [HANDLE_W-1:0] dsp_h_n, acct_h_n;
  logic [LW-1:0]       dsp_l_n;
  logic [TIME_W-1:0]   acct_t_n;

  always_comb begin
    prio_n   = prio_q;   run_h_n  = run_h_q;  run_m_n  = run_m_q;  run_t_n = run_t_q;
    pend_v_n = pend_v_q; pend_h_n = pend_h_q; pend_m_n = pend_m_q;
    pend_l_n = pend_l_q; pend_t_n = pend_t_q;
    dsp_v_n  = 1'b0; dsp_c_n = dsp_core; dsp_h_n = dsp_handle; dsp_l_n = dsp_level;
    acct_v_n = 1'b0; acct_h_n = acct_handle; acct_t_n = acct_time;
    if (go) begin
      if (prio_q[sel_core] != '0) begin
        pend_v_n[sel_core] = 1'b1;
        pend_h_n[sel_core] = run_h_q[sel_core];
        pend_m_n[sel_core] = run_m_q[sel_core];
        pend_l_n[sel_core] = LW'(prio_q[sel_core] - PW'(1));
        pend_t_n[sel_core] = run_t_q[sel_core];
      end
      run_h_n[sel_core] = head_h[sel_lvl];
      run_m_n[sel_core] = head_m[sel_lvl];
      run_t_n[sel_core] = rtc;
      prio_n[sel_core]  = PW'(sel_lvl) + PW'(1);
      dsp_v_n = 1'b1;
      dsp_c_n = sel_core;
      dsp_h_n = head_h[sel_lvl];
      dsp_l_n = sel_lvl;
    end
    if (ret_ok) begin
      pend_v_n[c_core] = 1'b0;
      acct_v_n = 1'b1;
      acct_h_n = pend_h_q[c_core];
      acct_t_n = rtc - pend_t_q[c_core];
    end
    if (is_exit && prio_q[c_core] != '0) begin
      prio_n[c_core] = '0;
      acct_v_n = 1'b1;
      acct_h_n = run_h_q[c_core];
      acct_t_n = rtc - run_t_q[c_core];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        prio_q[c] <= '0;   run_h_q[c] <= '0;  run_m_q[c] <= '0;  run_t_q[c] <= '0;
        pend_h_q[c] <= '0; pend_m_q[c] <= '0; pend_l_q[c] <= '0; pend_t_q[c] <= '0;
      end
      pend_v_q <= '0;
      dsp_valid <= 1'b0; dsp_core <= '0; dsp_handle <= '0; dsp_level <= '0;
      acct_valid <= 1'b0; acct_handle <= '0; acct_time <= '0;
    end else begin
      prio_q <= prio_n;   run_h_q <= run_h_n;  run_m_q <= run_m_n;  run_t_q <= run_t_n;
      pend_v_q <= pend_v_n; pend_h_q <= pend_h_n; pend_m_q <= pend_m_n;
      pend_l_q <= pend_l_n; pend_t_q <= pend_t_n;
      dsp_valid <= dsp_v_n; dsp_core <= dsp_c_n; dsp_handle <= dsp_h_n; dsp_level <= dsp_l_n;
      acct_valid <= acct_v_n; acct_handle <= acct_h_n; acct_time <= acct_t_n;
    end
  end

  a_r4_strict_rank: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (PW'(sel_lvl) + PW'(1) > prio_q[sel_core]));
  a_r5_mask_ok: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> head_m[sel_lvl][sel_core]);
  a_r6_no_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !pend_v_q[sel_core]);
  a_r9_prio_updated: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid |-> (prio_q[dsp_core] == PW'(dsp_level) + PW'(1)));
endmodule

// File: tb/sim_thread_dispatch.sv
module sim_thread_dispatch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_last;
  logic [31:0] in_data, rtc;
  logic        dsp_valid, acct_valid;
  logic [1:0]  dsp_core;
  logic [7:0]  dsp_handle, acct_handle, q_ovf;
  logic [2:0]  dsp_level;
  logic [31:0] acct_time;

  always #4 clk = ~clk;

  thread_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .rtc(rtc), .dsp_valid(dsp_valid), .dsp_core(dsp_core),
    .dsp_handle(dsp_handle), .dsp_level(dsp_level), .acct_valid(acct_valid),
    .acct_handle(acct_handle), .acct_time(acct_time), .q_ovf(q_ovf)
  );

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [7:0] h,
                                     input logic [5:0] l, input logic [7:0] m,
                                     input logic [5:0] idx);
    return {op, h, l, m, idx};
  endfunction

  typedef struct packed {
    logic [31:0] w0;
    logic [6:0]  nw;
    logic [31:0] rtc;
    logic        ed;
    logic [1:0]  ec;
    logic [7:0]  eh;
    logic        ea;
    logic [7:0]  eah;
    logic [31:0] eat;
    logic        eov;
    logic [3:0]  tag;
  } step_t;

  function automatic step_t st(input logic [3:0] op, input logic [7:0] h,
      input logic [5:0] l, input logic [7:0] m, input logic [5:0] idx,
      input logic [6:0] nw, input logic [31:0] t, input logic ed,
      input logic [1:0] ec, input logic [7:0] eh, input logic ea,
      input logic [7:0] eah, input logic [31:0] eat, input logic eov,
      input logic [3:0] tag);
    step_t s;
    s.w0 = mk(op, h, l, m, idx); s.nw = nw; s.rtc = t;
    s.ed = ed; s.ec = ec; s.eh = eh; s.ea = ea; s.eah = eah; s.eat = eat;
    s.eov = eov; s.tag = tag;
    return s;
  endfunction

  // op: 1 set-vector, 2 enqueue, 3 interrupt, 4 state-returned, 5 exit
  localparam int NSTEP = 22;
  localparam step_t TBL [NSTEP] = '{
    st(2, 8'h11, 2, 8'hF, 0, 1,  100, 1, 0, 8'h11, 0, 0,     0,   0, 5),
    st(2, 8'h12, 2, 8'hF, 0, 1,  200, 1, 1, 8'h12, 0, 0,     0,   0, 5),
    st(2, 8'h13, 1, 8'h1, 0, 1,  300, 0, 0, 0,     0, 0,     0,   0, 4),
    st(2, 8'h14, 5, 8'h3, 0, 1,  400, 1, 0, 8'h14, 0, 0,     0,   0, 5),
    st(4, 8'h00, 0, 8'h0, 0, 1,  550, 1, 2, 8'h11, 1, 8'h11, 450, 0, 6),
    st(2, 8'h15, 3, 8'h2, 0, 1,  600, 1, 1, 8'h15, 0, 0,     0,   0, 4),
    st(2, 8'h16, 2, 8'h2, 0, 1,  700, 0, 0, 0,     0, 0,     0,   0, 2),
    st(4, 8'h00, 0, 8'h0, 1, 1,  900, 1, 3, 8'h12, 1, 8'h12, 700, 0, 6),
    st(5, 8'h00, 0, 8'h0, 1, 1, 1000, 1, 1, 8'h16, 1, 8'h15, 400, 0, 2),
    st(1, 8'h20, 7, 8'h1, 3, 3, 1050, 0, 0, 0,     0, 0,     0,   0, 1),
    st(3, 8'h00, 0, 8'h0, 3, 1, 1100, 1, 0, 8'h20, 0, 0,     0,   0, 3),
    st(2, 8'h30, 0, 8'h4, 0, 1, 1200, 0, 0, 0,     0, 0,     0,   0, 8),
    st(2, 8'h31, 0, 8'h4, 0, 1, 1200, 0, 0, 0,     0, 0,     0,   0, 8),
    st(2, 8'h32, 0, 8'h4, 0, 1, 1200, 0, 0, 0,     0, 0,     0,   0, 8),
    st(2, 8'h33, 0, 8'h4, 0, 1, 1200, 0, 0, 0,     0, 0,     0,   0, 8),
    st(2, 8'h34, 0, 8'h4, 0, 1, 1200, 0, 0, 0,     0, 0,     0,   1, 8),
    st(5, 8'h00, 0, 8'h0, 2, 1, 1300, 1, 2, 8'h30, 1, 8'h11, 750, 1, 7),
    st(5, 8'h00, 0, 8'h0, 2, 1, 1400, 1, 2, 8'h31, 1, 8'h30, 100, 1, 8),
    st(5, 8'h00, 0, 8'h0, 2, 1, 1500, 1, 2, 8'h32, 1, 8'h31, 100, 1, 8),
    st(5, 8'h00, 0, 8'h0, 2, 1, 1600, 1, 2, 8'h33, 1, 8'h32, 100, 1, 8),
    st(5, 8'h00, 0, 8'h0, 2, 1, 1700, 0, 0, 0,     1, 8'h33, 100, 1, 8),
    st(4, 8'h00, 0, 8'h0, 3, 1, 1800, 0, 0, 0,     0, 0,     0,   1, 6)
  };

  function automatic string tname(input logic [3:0] t);
    case (t)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_dsp = 0, n_acct = 0;
  logic [1:0]  l_core;
  logic [7:0]  l_h, l_ah;
  logic [2:0]  l_lvl;
  logic [31:0] l_at;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && dsp_valid) begin
      n_dsp++; l_core = dsp_core; l_h = dsp_handle; l_lvl = dsp_level;
    end
    if (rst_n && acct_valid) begin
      n_acct++; l_ah = acct_handle; l_at = acct_time;
    end
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic send(input logic [31:0] w0, input int nw);
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      // trailing words look like a ready-to-run enqueue at level 7
      in_data  = (i == 0) ? w0 : mk(2, 8'h7F, 7, 8'hF, 0);
      in_last  = (i == nw - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int bd, ba;
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0; rtc = '0;
    idle(3);
    // R10 reset state
    chk(dsp_valid == 1'b0, "R10", "dsp_valid in reset", dsp_valid, 0);
    chk(acct_valid == 1'b0, "R10", "acct_valid in reset", acct_valid, 0);
    chk(q_ovf == 8'h00, "R10", "q_ovf in reset", q_ovf, 0);
    rst_n = 1'b1;
    idle(2);

    for (int s = 0; s < NSTEP; s++) begin
      step_t e;
      e = TBL[s];
      rtc = e.rtc;
      bd = n_dsp; ba = n_acct;
      send(e.w0, int'(e.nw));
      idle(5);
      chk((n_dsp - bd) == int'(e.ed), tname(e.tag), $sformatf("step %0d dispatch count", s),
          n_dsp - bd, e.ed);
      if (e.ed) begin
        chk(l_core == e.ec, tname(e.tag), $sformatf("step %0d core", s), l_core, e.ec);
        chk(l_h == e.eh, tname(e.tag), $sformatf("step %0d handle", s), l_h, e.eh);
      end
      chk((n_acct - ba) == int'(e.ea), "R7", $sformatf("step %0d accounting count", s),
          n_acct - ba, e.ea);
      if (e.ea) begin
        chk(l_ah == e.eah, "R7", $sformatf("step %0d charged handle", s), l_ah, e.eah);
        chk(l_at == e.eat, "R7", $sformatf("step %0d run time", s), l_at, e.eat);
      end
      chk(q_ovf[0] == e.eov, "R8", $sformatf("step %0d overflow level 0", s), q_ovf[0], e.eov);
    end

    // R9: two candidates for core 3 back to back, only the higher one goes
    bd = n_dsp;
    rtc = 32'd2000;
    @(negedge clk);
    in_valid = 1'b1; in_last = 1'b1; in_data = mk(2, 8'h40, 6, 8'h8, 0);
    @(negedge clk);
    in_data = mk(2, 8'h41, 7, 8'h8, 0);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    idle(6);
    chk((n_dsp - bd) == 1, "R9", "single dispatch on updated priority", n_dsp - bd, 1);
    chk(l_core == 2'd3 && l_h == 8'h41, "R9", "dispatch core/handle", {l_core, l_h}, {2'd3, 8'h41});
    chk(l_lvl == 3'd7, "R9", "dispatch level", l_lvl, 7);

    // R10: reset mid-run clears flags and idles all cores
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    chk(q_ovf == 8'h00, "R10", "q_ovf after reset", q_ovf, 0);
    @(negedge clk); rst_n = 1'b1;
    bd = n_dsp;
    send(mk(2, 8'h50, 0, 8'hF, 0), 1);
    idle(5);
    chk((n_dsp - bd) == 1 && l_core == 2'd0 && l_h == 8'h50, "R10",
        "level 0 thread goes to idle core 0 after reset", {l_core, l_h}, {2'd0, 8'h50});

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule